// File: doc/BRIEF.md
# Auxiliary Fault Status Register Access Arbiter

This block decides what happens to one system-register access aimed at a pair of auxiliary fault status registers. One 64-bit copy belongs to the kernel level (EL1) and one to the hypervisor level (EL2). Each access is described by its encoding fields (op0, op1, CRn, CRm, op2), a direction bit, the current exception level, hypervisor control bits, fine-grained trap bits and feature-present straps. The block combines these in one cycle and gives one outcome: the access is undefined, it traps to EL2 with a syndrome class, it is redirected to a memory slot, or it reads or writes one of the two stored registers.

The block holds both registers. Read data is returned in the same cycle as the strobe. A write that is allowed takes effect at the next clock edge. Whatever handles the trap and whatever services the redirect live outside this block. They consume the outcome flags, the syndrome class and the redirect offset.

Top module: `aux_fault_reg_arbiter`

## Requirements
- R1: An access matches the hypervisor accessor when op0=3, op1=4, CRn=5, CRm=1 and op2=1. It matches the kernel accessor when the fields are the same except op1=0. Any other encoding raises `res_nomatch` and leaves both stored registers unchanged.
- R2: When `acc_valid` is high, exactly one of `res_nomatch`, `res_undef`, `res_trap`, `res_redirect`, `res_ok` is high. When `acc_valid` is low, all five are low.
- R3: A matching access with `cur_el`=0 is undefined, whichever accessor it uses.
- R4: An EL1 access to the hypervisor accessor traps with class 0x18 when `nv_field[0]` is 1. Otherwise it is undefined.
- R5: EL2 and EL3 accesses to the hypervisor accessor read or write the EL2 register.
- R6: For an EL1 access to the kernel accessor, the first rule checked is a coarse trap with class 0x18. It fires when `el2_enabled` is set and the direction's bit is set: `hcr_trvm` for reads, `hcr_tvm` for writes.
- R7: Next in order is a fine-grained trap with class 0x18. It fires when all of these hold: `el2_enabled` is set, `feat_fgt` is set, `feat_el3` is clear or `scr_fgt_en` is set, and the direction's trap bit is set (`fgt_rd_trap` for reads, `fgt_wr_trap` for writes).
- R8: Next in order, when `nv_field`=3'b111, the access is redirected and `res_redir_off` reads 0x130. The offset is 0 for any other outcome.
- R9: An EL1 access to the kernel accessor that meets none of the conditions in R6 to R8 reads or writes the EL1 register.
- R10: An EL2 access to the kernel accessor uses the EL2 register when `host_mode` is 1 and the EL1 register otherwise. An EL3 access to the kernel accessor always uses the EL1 register.
- R11: While `feat_el2` is 0, the EL2 register reads as zero, and writes to it (including from EL3) are dropped.
- R12: Both registers reset to zero on a synchronous active-low reset. A write with an ok outcome is visible from the next clock edge. `res_rdata` shows the selected register during an ok read and zero otherwise. `res_syndrome` is zero unless a trap is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | EL2 enabled in current security state |
| host_mode | input | 1 | Hypervisor runs in host mode |
| nv_field | input | 3 | Effective nested-virtualization bits |
| hcr_trvm | input | 1 | Coarse read trap for virtual-memory registers |
| hcr_tvm | input | 1 | Coarse write trap for virtual-memory registers |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit for this register |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit for this register |
| scr_fgt_en | input | 1 | EL3 enable for fine-grained traps |
| feat_el2 | input | 1 | EL2 implemented |
| feat_el3 | input | 1 | EL3 implemented |
| feat_fgt | input | 1 | Fine-grained trap feature present |
| res_nomatch | output | 1 | Encoding matches neither accessor |
| res_undef | output | 1 | Access is undefined |
| res_trap | output | 1 | Access traps to EL2 |
| res_redirect | output | 1 | Access is redirected to memory |
| res_ok | output | 1 | Access served by a stored register |
| res_syndrome | output | 6 | Syndrome class of a trap |
| res_redir_off | output | 12 | Memory offset of a redirect |
| res_rdata | output | 64 | Read data |

## Verification
The outcome flags, syndrome class, redirect offset and read data are combinational, so they are due in the same cycle as the strobe. The bench drives inputs at the falling edge and compares 1 ns later against a behavioural model. A write changes state only at the next rising edge. The model copies the written value into its own registers at that edge, so the first access that can observe the write is the one in the following cycle. Directed priority cases are followed by a long run of random accesses, and every cycle is compared.

// File: rtl/afr_pkg.sv
`timescale 1ns/1ps
package afr_pkg;

   typedef struct packed {
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } afr_enc_t;

   typedef enum logic [2:0] {
      OUT_NONE    = 3'd0,
      OUT_NOMATCH = 3'd1,
      OUT_UNDEF   = 3'd2,
      OUT_TRAP    = 3'd3,
      OUT_REDIR   = 3'd4,
      OUT_OK      = 3'd5
   } afr_outcome_e;

   typedef enum logic [1:0] {
      LVL_0 = 2'd0,
      LVL_1 = 2'd1,
      LVL_2 = 2'd2,
      LVL_3 = 2'd3
   } afr_lvl_e;

   localparam afr_enc_t ENC_HYP = '{op0: 2'b11, op1: 3'b100, crn: 4'b0101, crm: 4'b0001, op2: 3'b001};
   localparam afr_enc_t ENC_LOW = '{op0: 2'b11, op1: 3'b000, crn: 4'b0101, crm: 4'b0001, op2: 3'b001};

   localparam int NUM_COPIES = 2;
   localparam int IDX_LOW    = 0;
   localparam int IDX_HYP    = 1;

endpackage

// File: rtl/afr_decode.sv
`timescale 1ns/1ps
module afr_decode
   import afr_pkg::*;
(
   input  afr_enc_t enc,
   output logic     hit_hyp,
   output logic     hit_low
);

   localparam int NUM_ACC = 2;
   localparam afr_enc_t ACC_TAB [NUM_ACC] = '{ENC_LOW, ENC_HYP};

   logic [NUM_ACC-1:0] hit_vec;

   for (genvar g = 0; g < NUM_ACC; g++) begin : g_match
      assign hit_vec[g] = (enc == ACC_TAB[g]);
   end

   assign hit_low = hit_vec[0];
   assign hit_hyp = hit_vec[1];

endmodule

// File: rtl/afr_route.sv
`timescale 1ns/1ps
module afr_route
   import afr_pkg::*;
(
   input  logic         valid,
   input  logic         write,
   input  logic         hit_hyp,
   input  logic         hit_low,
   input  logic [1:0]   lvl,
   input  logic         el2_en,
   input  logic         host,
   input  logic [2:0]   nv,
   input  logic         trvm,
   input  logic         tvm,
   input  logic         fgt_rd,
   input  logic         fgt_wr,
   input  logic         fgt_en,
   input  logic         has_fgt,
   input  logic         has_el3,
   output afr_outcome_e outcome,
   output logic         sel_hyp
);

   afr_lvl_e lvl_e;
   logic     coarse_hit;
   logic     fine_hit;

   assign lvl_e      = afr_lvl_e'(lvl);
   assign coarse_hit = el2_en & (write ? tvm : trvm);
   assign fine_hit   = el2_en & has_fgt & (~has_el3 | fgt_en) & (write ? fgt_wr : fgt_rd);

   always_comb begin
      outcome = OUT_NONE;
      sel_hyp = 1'b0;
      if (valid) begin
         if (!hit_hyp && !hit_low) begin
            outcome = OUT_NOMATCH;
         end else if (lvl_e == LVL_0) begin
            outcome = OUT_UNDEF;
         end else if (hit_hyp) begin
            if (lvl_e == LVL_1) begin
               outcome = nv[0] ? OUT_TRAP : OUT_UNDEF;
            end else begin
               outcome = OUT_OK;
               sel_hyp = 1'b1;
            end
         end else begin
            unique case (lvl_e)
               LVL_1: begin
                  if (coarse_hit)          outcome = OUT_TRAP;
                  else if (fine_hit)       outcome = OUT_TRAP;
                  else if (nv == 3'b111)   outcome = OUT_REDIR;
                  else                     outcome = OUT_OK;
               end
               LVL_2: begin
                  outcome = OUT_OK;
                  sel_hyp = host;
               end
               default: begin
                  outcome = OUT_OK;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/afr_regfile.sv
`timescale 1ns/1ps
module afr_regfile #(
   parameter int DATA_W = 64,
   parameter int COPIES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [COPIES-1:0]             wr_en,
   input  logic [DATA_W-1:0]             wdata,
   output logic [COPIES-1:0][DATA_W-1:0] q
);

   for (genvar g = 0; g < COPIES; g++) begin : g_copy
      always_ff @(posedge clk) begin
         if (!rst_n)        q[g] <= '0;
         else if (wr_en[g]) q[g] <= wdata;
      end

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en[g] |=> $stable(q[g])); // R1
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en[g] |=> (q[g] == $past(wdata))); // R12
   end

endmodule

// File: rtl/aux_fault_reg_arbiter.sv
`timescale 1ns/1ps
module aux_fault_reg_arbiter
   import afr_pkg::*;
#(
   parameter int          DATA_W     = 64,
   parameter int          SYND_W     = 6,
   parameter int          TRAP_CLASS = 24,
   parameter int          OFF_W      = 12,
   parameter int          REDIR_OFF  = 304
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_op0,
   input  logic [2:0]        acc_op1,
   input  logic [3:0]        acc_crn,
   input  logic [3:0]        acc_crm,
   input  logic [2:0]        acc_op2,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [1:0]        cur_el,
   input  logic              el2_enabled,
   input  logic              host_mode,
   input  logic [2:0]        nv_field,
   input  logic              hcr_trvm,
   input  logic              hcr_tvm,
   input  logic              fgt_rd_trap,
   input  logic              fgt_wr_trap,
   input  logic              scr_fgt_en,
   input  logic              feat_el2,
   input  logic              feat_el3,
   input  logic              feat_fgt,
   output logic              res_nomatch,
   output logic              res_undef,
   output logic              res_trap,
   output logic              res_redirect,
   output logic              res_ok,
   output logic [SYND_W-1:0] res_syndrome,
   output logic [OFF_W-1:0]  res_redir_off,
   output logic [DATA_W-1:0] res_rdata
);

   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end
   if (TRAP_CLASS >= (1 << SYND_W)) begin : g_bad_synd
      $error("TRAP_CLASS does not fit SYND_W");
   end
   if (REDIR_OFF >= (1 << OFF_W)) begin : g_bad_off
      $error("REDIR_OFF does not fit OFF_W");
   end

   localparam logic [SYND_W-1:0] SYND_VAL = SYND_W'(TRAP_CLASS);
   localparam logic [OFF_W-1:0]  OFF_VAL  = OFF_W'(REDIR_OFF);

   afr_enc_t     enc;
   logic         hit_hyp;
   logic         hit_low;
   afr_outcome_e outcome;
   logic         sel_hyp;
   logic [NUM_COPIES-1:0]             wr_en;
   logic [NUM_COPIES-1:0][DATA_W-1:0] q;
   logic         do_write;

   assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

   afr_decode u_decode (
      .enc     (enc),
      .hit_hyp (hit_hyp),
      .hit_low (hit_low)
   );

   afr_route u_route (
      .valid   (acc_valid),
      .write   (acc_write),
      .hit_hyp (hit_hyp),
      .hit_low (hit_low),
      .lvl     (cur_el),
      .el2_en  (el2_enabled),
      .host    (host_mode),
      .nv      (nv_field),
      .trvm    (hcr_trvm),
      .tvm     (hcr_tvm),
      .fgt_rd  (fgt_rd_trap),
      .fgt_wr  (fgt_wr_trap),
      .fgt_en  (scr_fgt_en),
      .has_fgt (feat_fgt),
      .has_el3 (feat_el3),
      .outcome (outcome),
      .sel_hyp (sel_hyp)
   );

   assign res_nomatch  = (outcome == OUT_NOMATCH);
   assign res_undef    = (outcome == OUT_UNDEF);
   assign res_trap     = (outcome == OUT_TRAP);
   assign res_redirect = (outcome == OUT_REDIR);
   assign res_ok       = (outcome == OUT_OK);

   assign res_syndrome  = res_trap     ? SYND_VAL : '0;
   assign res_redir_off = res_redirect ? OFF_VAL  : '0;

   assign do_write         = res_ok & acc_write;
   assign wr_en[IDX_HYP]   = do_write & sel_hyp & feat_el2;
   assign wr_en[IDX_LOW]   = do_write & ~sel_hyp;

   afr_regfile #(
      .DATA_W (DATA_W),
      .COPIES (NUM_COPIES)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (acc_wdata),
      .q     (q)
   );

   always_comb begin
      res_rdata = '0;
      if (res_ok && !acc_write) begin
         if (sel_hyp) res_rdata = feat_el2 ? q[IDX_HYP] : '0;
         else         res_rdata = q[IDX_LOW];
      end
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> $onehot({res_nomatch, res_undef, res_trap, res_redirect, res_ok})); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> ({res_nomatch, res_undef, res_trap, res_redirect, res_ok} == 5'b0)); // R2
   AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (hit_hyp || hit_low) && cur_el == 2'd0) |-> res_undef); // R3
   AST_EL1_HYP_NV: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && hit_hyp && cur_el == 2'd1) |-> (res_trap == nv_field[0])); // R4
   AST_SYND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_trap |-> (res_syndrome == '0)); // R12
   AST_NOMATCH_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
      res_nomatch |-> (wr_en == '0)); // R1
   AST_ABSENT_HYP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!feat_el2 && res_ok && sel_hyp) |-> (res_rdata == '0 && !wr_en[IDX_HYP])); // R11

endmodule

// File: tb/aux_fault_reg_arbiter_bench.sv
`timescale 1ns/1ps
module aux_fault_reg_arbiter_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        acc_valid, acc_write;
   logic [1:0]  acc_op0;
   logic [2:0]  acc_op1;
   logic [3:0]  acc_crn, acc_crm;
   logic [2:0]  acc_op2;
   logic [63:0] acc_wdata;
   logic [1:0]  cur_el;
   logic        el2_enabled, host_mode;
   logic [2:0]  nv_field;
   logic        hcr_trvm, hcr_tvm, fgt_rd_trap, fgt_wr_trap, scr_fgt_en;
   logic        feat_el2, feat_el3, feat_fgt;
   logic        res_nomatch, res_undef, res_trap, res_redirect, res_ok;
   logic [5:0]  res_syndrome;
   logic [11:0] res_redir_off;
   logic [63:0] res_rdata;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [63:0] m_low, m_hyp;

   always #2.5 clk = ~clk;

   aux_fault_reg_arbiter u_aux_fault_reg_arbiter (.*);

   // kind: 0 idle, 1 nomatch, 2 undef, 3 trap, 4 redirect, 5 ok
   task automatic model(output int kind, output bit to_hyp, output string tag);
      bit is_hyp, is_low;
      is_hyp = acc_op0 == 2'd3 && acc_op1 == 3'd4 && acc_crn == 4'd5 && acc_crm == 4'd1 && acc_op2 == 3'd1;
      is_low = acc_op0 == 2'd3 && acc_op1 == 3'd0 && acc_crn == 4'd5 && acc_crm == 4'd1 && acc_op2 == 3'd1;
      to_hyp = 0;
      if (!acc_valid) begin kind = 0; tag = "R2"; end
      else if (!is_hyp && !is_low) begin kind = 1; tag = "R1"; end
      else if (cur_el == 0) begin kind = 2; tag = "R3"; end
      else if (is_hyp && cur_el == 1) begin kind = nv_field[0] ? 3 : 2; tag = "R4"; end
      else if (is_hyp) begin kind = 5; to_hyp = 1; tag = feat_el2 ? "R5" : "R11"; end
      else if (cur_el == 1) begin
         if (el2_enabled && (acc_write ? hcr_tvm : hcr_trvm)) begin kind = 3; tag = "R6"; end
         else if (el2_enabled && feat_fgt && (!feat_el3 || scr_fgt_en) &&
                  (acc_write ? fgt_wr_trap : fgt_rd_trap)) begin kind = 3; tag = "R7"; end
         else if (nv_field == 3'b111) begin kind = 4; tag = "R8"; end
         else begin kind = 5; tag = "R9"; end
      end
      else if (cur_el == 2) begin kind = 5; to_hyp = host_mode; tag = "R10"; end
      else begin kind = 5; tag = "R10"; end
   endtask

   task automatic step();
      int kind; bit to_hyp; string tag;
      logic [4:0]  e_flags, a_flags;
      logic [63:0] e_rd;
      logic [5:0]  e_syn;
      logic [11:0] e_off;
      #1;
      model(kind, to_hyp, tag);
      e_flags = {kind == 1, kind == 2, kind == 3, kind == 4, kind == 5};
      e_syn   = (kind == 3) ? 6'h18 : 6'h00;
      e_off   = (kind == 4) ? 12'h130 : 12'h000;
      e_rd    = '0;
      if (kind == 5 && !acc_write) e_rd = to_hyp ? (feat_el2 ? m_hyp : 64'd0) : m_low;
      a_flags = {res_nomatch, res_undef, res_trap, res_redirect, res_ok};
      checks++;
      if (a_flags !== e_flags || res_syndrome !== e_syn || res_redir_off !== e_off) begin
         failures++;
         $display("FAIL %s outcome: actual flags=%b syn=%h off=%h expected flags=%b syn=%h off=%h",
                  tag, a_flags, res_syndrome, res_redir_off, e_flags, e_syn, e_off);
      end
      checks++;
      if (res_rdata !== e_rd) begin
         failures++;
         $display("FAIL %s/R12 rdata: actual=%h expected=%h", tag, res_rdata, e_rd);
      end
      @(posedge clk);
      if (kind == 5 && acc_write) begin
         if (to_hyp) begin if (feat_el2) m_hyp = acc_wdata; end
         else m_low = acc_wdata;
      end
      @(negedge clk);
   endtask

   task automatic defaults();
      acc_valid = 0; acc_write = 0;
      acc_op0 = 2'd3; acc_op1 = 3'd0; acc_crn = 4'd5; acc_crm = 4'd1; acc_op2 = 3'd1;
      acc_wdata = '0; cur_el = 2'd3;
      el2_enabled = 1; host_mode = 0; nv_field = 3'd0;
      hcr_trvm = 0; hcr_tvm = 0; fgt_rd_trap = 0; fgt_wr_trap = 0; scr_fgt_en = 0;
      feat_el2 = 1; feat_el3 = 1; feat_fgt = 1;
   endtask

   task automatic acc(input bit wr, input bit hyp, input logic [1:0] el, input logic [63:0] wd);
      acc_valid = 1; acc_write = wr; acc_op1 = hyp ? 3'd4 : 3'd0;
      acc_op0 = 2'd3; acc_crn = 4'd5; acc_crm = 4'd1; acc_op2 = 3'd1;
      cur_el = el; acc_wdata = wd;
      step();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
   end

   initial begin
      defaults();
      m_low = '0; m_hyp = '0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R2 idle, R12 reset values
      step();
      acc(0, 1, 3, 0);
      acc(0, 0, 3, 0);
      // R5 and R10 writes then reads
      acc(1, 1, 3, 64'hA5A5_0000_1111_2222);
      acc(1, 0, 3, 64'h0123_4567_89AB_CDEF);
      acc(0, 1, 2, 0);
      acc(0, 0, 3, 0);
      host_mode = 1;
      acc(1, 0, 2, 64'hDEAD_BEEF_0000_0001); // R10 host -> EL2 copy
      acc(0, 1, 3, 0);
      host_mode = 0;
      acc(0, 0, 2, 0);
      // R3
      acc(0, 0, 0, 0);
      acc(1, 1, 0, 64'hFFFF);
      // R4
      nv_field = 3'b001; acc(0, 1, 1, 0);
      nv_field = 3'b110; acc(1, 1, 1, 64'h1);
      nv_field = 3'b000;
      // R6
      hcr_trvm = 1; acc(0, 0, 1, 0);
      acc(1, 0, 1, 64'h77); // TVM clear -> ok write (R9)
      hcr_tvm = 1; acc(1, 0, 1, 64'h88);
      el2_enabled = 0; acc(0, 0, 1, 0);
      el2_enabled = 1; hcr_trvm = 0; hcr_tvm = 0;
      // R7
      fgt_rd_trap = 1; scr_fgt_en = 1; acc(0, 0, 1, 0);
      scr_fgt_en = 0; acc(0, 0, 1, 0);
      feat_el3 = 0; acc(0, 0, 1, 0);
      feat_fgt = 0; acc(0, 0, 1, 0);
      feat_fgt = 1; feat_el3 = 1; scr_fgt_en = 1; fgt_rd_trap = 0;
      fgt_wr_trap = 1; acc(1, 0, 1, 64'h99);
      nv_field = 3'b111; acc(1, 0, 1, 64'h99); // R7 above R8
      hcr_tvm = 1; acc(1, 0, 1, 64'h99);       // R6 above R7
      hcr_tvm = 0; fgt_wr_trap = 0;
      // R8
      acc(1, 0, 1, 64'hBAD);
      acc(0, 0, 1, 0);
      nv_field = 3'b011; acc(0, 0, 1, 0);
      nv_field = 3'b000;
      // R1 no-match write, then read back both
      acc_valid = 1; acc_write = 1; acc_op1 = 3'd2; acc_wdata = 64'hCAFE; cur_el = 3; step();
      acc_op1 = 3'd0; acc_crm = 4'd2; step();
      acc(0, 0, 3, 0);
      acc(0, 1, 3, 0);
      // R11
      feat_el2 = 0; el2_enabled = 0;
      acc(1, 1, 3, 64'h5555);
      acc(0, 1, 3, 0);
      feat_el2 = 1; el2_enabled = 1;
      acc(0, 1, 3, 0);
      // random mix
      for (int i = 0; i < 600; i++) begin
         int sel;
         sel = $urandom_range(0, 9);
         acc_valid = ($urandom_range(0, 7) != 0);
         acc_write = $urandom_range(0, 1);
         acc_op0 = (sel == 0) ? 2'($urandom) : 2'd3;
         acc_op1 = (sel == 1) ? 3'($urandom) : (sel < 6 ? 3'd0 : 3'd4);
         acc_crn = (sel == 2) ? 4'($urandom) : 4'd5;
         acc_crm = 4'd1; acc_op2 = 3'd1;
         acc_wdata = {$urandom, $urandom};
         cur_el = 2'($urandom);
         el2_enabled = $urandom_range(0, 1); host_mode = $urandom_range(0, 1);
         nv_field = ($urandom_range(0, 3) == 0) ? 3'b111 : 3'($urandom);
         hcr_trvm = ($urandom_range(0, 3) == 0); hcr_tvm = ($urandom_range(0, 3) == 0);
         fgt_rd_trap = $urandom_range(0, 1); fgt_wr_trap = $urandom_range(0, 1);
         scr_fgt_en = $urandom_range(0, 1);
         feat_el3 = $urandom_range(0, 1); feat_fgt = $urandom_range(0, 1);
         step();
      end
      finish_run();
   end

endmodule